// File: doc/BRIEF.md
# Per-CPU Interrupt Presentation Controller

This block sits in front of one processor and decides which single interrupt that processor sees at a time. It keeps a 32-bit pending word. The upper byte is the processor's current priority and the lower 24 bits are the number of the source now waiting. Next to the word it keeps the priority of the waiting interrupt and the priority of an inter-processor request. A smaller priority value wins. 0xFF is the least favoured value, and in the pending priority it means that nothing is waiting.

Interrupt sources offer work on the arrival port. A request that loses the comparison is handed back on the reject port, so that its source can offer it again later. A request that wins displaces the one already held, and that held request is handed back instead. The inter-processor request is held internally under the fixed source number 2. It competes like any other source, but since no source owns it, it never appears on the reject port. The processor drives one-cycle command strobes: accept, end-of-interrupt, set current priority, set inter-processor priority and poll. Accept and poll return a response one cycle later. End-of-interrupt forwards a source number to the sources. Some commands also pulse a resend request, which asks the sources to offer again what they were refused.

The pending slot is a three-state machine held in a state register: EMPTY, SOURCE and IPI. Its transitions are:
- ARRIVE_WIN takes EMPTY, SOURCE or IPI to SOURCE.
- IPI_LOAD takes EMPTY or SOURCE to IPI, and also reloads IPI when the inter-processor priority gets better.
- ACCEPT takes any state to EMPTY.
- PRIO_CLEAR takes SOURCE or IPI to EMPTY.
- Every other event leaves the state where it is.

Top module: `irq_presenter`

## Requirements
- R1: After reset the pending word is 0, the pending priority is 0xFF, the inter-processor priority is 0xFF, and every output is low.
- R2: Command codes on cmd_op are 0 accept, 1 end-of-interrupt, 2 set current priority (value in cmd_data[7:0]), 3 set inter-processor priority (value in cmd_data[7:0]) and 4 poll. Codes 5 to 7 have no effect. Poll raises rsp_valid in the next cycle, with rsp_word = {current priority, pending source} and rsp_ipi = the inter-processor priority, and changes nothing.
- R3: An arrival whose priority is greater than or equal to the current priority is returned on the reject port in the next cycle, with its own source number.
- R4: An arrival is also returned when a source is already held whose pending priority is less than or equal to the arrival's priority.
- R5: A winning arrival hands a held external source back on the reject port. It then latches the new number and priority and raises irq_out.
- R6: Accept returns the whole pending word on rsp_word and lowers irq_out. The current priority becomes the old pending priority, the source field becomes 0 and the pending priority becomes 0xFF.
- R7: Set inter-processor priority stores the value. When the value is below the current priority, and no held source has a pending priority less than or equal to it, the block rejects any held external source, loads source number 2 with that priority and raises irq_out.
- R8: A held inter-processor request that is displaced or cleared never drives the reject port.
- R9: Setting a current priority below the old one clears a held request whose pending priority is greater than or equal to the new value. The clear rejects an external source, sets the pending priority to 0xFF and lowers irq_out. A held request with a better pending priority stays.
- R10: Setting a current priority equal to or above the old one while nothing is held pulses resend_req for one cycle. In the same cycle the inter-processor check of R7 runs against the new priority.
- R11: End-of-interrupt loads cmd_data[31:24] as the current priority and puts cmd_data[23:0] on eoi_src with eoi_valid for one cycle. When nothing is held it also pulses resend_req after the inter-processor check.
- R12: An arrival with source number 0 is ignored: nothing is rejected and nothing is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arr_valid | input | 1 | Arrival strobe from a source |
| arr_src | input | 24 | Source number of the arrival |
| arr_prio | input | 8 | Priority of the arrival |
| cmd_valid | input | 1 | Processor command strobe |
| cmd_op | input | 3 | Command code |
| cmd_data | input | 32 | Command operand |
| rsp_valid | output | 1 | Response to accept or poll |
| rsp_word | output | 32 | Returned pending word |
| rsp_ipi | output | 8 | Returned inter-processor priority |
| rej_valid | output | 1 | Hand-back strobe toward sources |
| rej_src | output | 24 | Source number handed back |
| eoi_valid | output | 1 | End-of-interrupt strobe toward sources |
| eoi_src | output | 24 | Source number being completed |
| resend_req | output | 1 | Asks sources to offer refused work again |
| irq_out | output | 1 | Interrupt line to the processor |

## Verification
The bench drives arrivals under several conditions:
- priorities at and below a current priority of zero, which separates the R3 bound from an off-by-one compare;
- an arrival equal to the held priority against one strictly better, which separates R4 from displacement;
- a zero source number, which must be ignored.

The inter-processor request is tried against these cases:
- as the newly held request, which must load;
- displaced by a better arrival, where the reject port must stay silent;
- displacing an external source, where the source must be rejected;
- cleared by a priority drop, where the reject port must again stay silent.

Priority writes that go down with and without a clear, and that go up with and without a held request, separate the clear path from the resend path. The same contrast between end-of-interrupt with and without a held request isolates the conditional resend.

// File: rtl/irqp_pkg.sv
package irqp_pkg;

    localparam int DEF_SRC_W  = 24;
    localparam int DEF_PRIO_W = 8;
    localparam int DEF_IPI_NUM = 2;

    typedef enum logic [1:0] {
        SLOT_EMPTY  = 2'd0,
        SLOT_SOURCE = 2'd1,
        SLOT_IPI    = 2'd2
    } slot_e;

    typedef enum logic [2:0] {
        CMD_ACCEPT   = 3'd0,
        CMD_EOI      = 3'd1,
        CMD_SET_PRIO = 3'd2,
        CMD_SET_IPI  = 3'd3,
        CMD_POLL     = 3'd4
    } cmd_e;

endpackage

// File: rtl/irqp_arrival_judge.sv
module irqp_arrival_judge #(
    parameter int PRIO_W = 8
) (
    input  logic [PRIO_W-1:0] cur_prio,
    input  logic              held,
    input  logic [PRIO_W-1:0] held_prio,
    input  logic [PRIO_W-1:0] in_prio,
    output logic              take
);
    // Wins only if strictly better than the processor and than any held request.
    always_comb begin
        take = (in_prio < cur_prio) && !(held && (held_prio <= in_prio));
    end
endmodule

// File: rtl/irqp_ipi_judge.sv
module irqp_ipi_judge #(
    parameter int PRIO_W = 8
) (
    input  logic [PRIO_W-1:0] ipi_prio,
    input  logic [PRIO_W-1:0] cur_prio,
    input  logic              held,
    input  logic [PRIO_W-1:0] held_prio,
    output logic              fire
);
    always_comb begin
        fire = (ipi_prio < cur_prio) && !(held && (held_prio <= ipi_prio));
    end
endmodule

// File: rtl/irqp_prio_judge.sv
module irqp_prio_judge #(
    parameter int PRIO_W = 8
) (
    input  logic [PRIO_W-1:0] old_prio,
    input  logic [PRIO_W-1:0] new_prio,
    input  logic              held,
    input  logic [PRIO_W-1:0] held_prio,
    output logic              clear,
    output logic              resend
);
    // Lowering may evict the held request; raising with nothing held asks for a resend.
    always_comb begin
        clear  = (new_prio < old_prio) && held && (new_prio <= held_prio);
        resend = (new_prio >= old_prio) && !held;
    end
endmodule

// File: rtl/irq_presenter.sv
module irq_presenter
    import irqp_pkg::*;
#(
    parameter int SRC_W   = DEF_SRC_W,
    parameter int PRIO_W  = DEF_PRIO_W,
    parameter int IPI_NUM = DEF_IPI_NUM
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    arr_valid,
    input  logic [SRC_W-1:0]        arr_src,
    input  logic [PRIO_W-1:0]       arr_prio,
    input  logic                    cmd_valid,
    input  logic [2:0]              cmd_op,
    input  logic [PRIO_W+SRC_W-1:0] cmd_data,
    output logic                    rsp_valid,
    output logic [PRIO_W+SRC_W-1:0] rsp_word,
    output logic [PRIO_W-1:0]       rsp_ipi,
    output logic                    rej_valid,
    output logic [SRC_W-1:0]        rej_src,
    output logic                    eoi_valid,
    output logic [SRC_W-1:0]        eoi_src,
    output logic                    resend_req,
    output logic                    irq_out
);
    localparam int WORD_W = PRIO_W + SRC_W;
    localparam logic [PRIO_W-1:0] PRIO_NONE = '1;
    localparam logic [SRC_W-1:0]  IPI_SRC   = SRC_W'(IPI_NUM);

    // Architectural state
    slot_e             slot_q, slot_d;
    logic [SRC_W-1:0]  xisr_q, xisr_d;
    logic [PRIO_W-1:0] cppr_q, cppr_d;
    logic [PRIO_W-1:0] pend_prio_q, pend_prio_d;
    logic [PRIO_W-1:0] ipi_prio_q, ipi_prio_d;

    // Next values of the registered outputs
    logic              rsp_v_d, rej_v_d, eoi_v_d, resend_d;
    logic [WORD_W-1:0] rsp_w_d;
    logic [PRIO_W-1:0] rsp_i_d;
    logic [SRC_W-1:0]  rej_s_d, eoi_s_d;

    cmd_e              op;
    logic              held;
    logic [PRIO_W-1:0] wr_prio, eoi_prio, ipi_eff, cppr_eff;
    logic              arr_take, ipi_fire, prio_clear, prio_resend;

    assign op       = cmd_e'(cmd_op);
    assign held     = (slot_q != SLOT_EMPTY);
    assign wr_prio  = cmd_data[PRIO_W-1:0];
    assign eoi_prio = cmd_data[WORD_W-1:SRC_W];

    // The IPI check compares against the values the current command installs.
    assign ipi_eff  = (cmd_valid && op == CMD_SET_IPI) ? wr_prio : ipi_prio_q;
    assign cppr_eff = (cmd_valid && op == CMD_EOI)      ? eoi_prio :
                      (cmd_valid && op == CMD_SET_PRIO) ? wr_prio  : cppr_q;

    irqp_arrival_judge #(.PRIO_W(PRIO_W)) u_arrival (
        .cur_prio (cppr_q),
        .held     (held),
        .held_prio(pend_prio_q),
        .in_prio  (arr_prio),
        .take     (arr_take)
    );

    irqp_ipi_judge #(.PRIO_W(PRIO_W)) u_ipi (
        .ipi_prio (ipi_eff),
        .cur_prio (cppr_eff),
        .held     (held),
        .held_prio(pend_prio_q),
        .fire     (ipi_fire)
    );

    irqp_prio_judge #(.PRIO_W(PRIO_W)) u_prio (
        .old_prio (cppr_q),
        .new_prio (wr_prio),
        .held     (held),
        .held_prio(pend_prio_q),
        .clear    (prio_clear),
        .resend   (prio_resend)
    );

    always_comb begin
        slot_d      = slot_q;
        xisr_d      = xisr_q;
        cppr_d      = cppr_q;
        pend_prio_d = pend_prio_q;
        ipi_prio_d  = ipi_prio_q;
        rsp_v_d     = 1'b0;
        rsp_w_d     = '0;
        rsp_i_d     = '0;
        rej_v_d     = 1'b0;
        rej_s_d     = '0;
        eoi_v_d     = 1'b0;
        eoi_s_d     = '0;
        resend_d    = 1'b0;

        if (cmd_valid) begin
            unique case (op)
                CMD_ACCEPT: begin
                    rsp_v_d     = 1'b1;
                    rsp_w_d     = {cppr_q, xisr_q};
                    rsp_i_d     = ipi_prio_q;
                    cppr_d      = pend_prio_q;
                    xisr_d      = '0;
                    pend_prio_d = PRIO_NONE;
                    slot_d      = SLOT_EMPTY;
                end
                CMD_EOI: begin
                    cppr_d  = eoi_prio;
                    eoi_v_d = 1'b1;
                    eoi_s_d = cmd_data[SRC_W-1:0];
                    if (!held) begin
                        resend_d = 1'b1;
                        if (ipi_fire) begin
                            slot_d      = SLOT_IPI;
                            xisr_d      = IPI_SRC;
                            pend_prio_d = ipi_eff;
                        end
                    end
                end
                CMD_SET_PRIO: begin
                    cppr_d = wr_prio;
                    if (prio_clear) begin
                        if (slot_q == SLOT_SOURCE) begin
                            rej_v_d = 1'b1;
                            rej_s_d = xisr_q;
                        end
                        slot_d      = SLOT_EMPTY;
                        xisr_d      = '0;
                        pend_prio_d = PRIO_NONE;
                    end else if (prio_resend) begin
                        resend_d = 1'b1;
                        if (ipi_fire) begin
                            slot_d      = SLOT_IPI;
                            xisr_d      = IPI_SRC;
                            pend_prio_d = ipi_eff;
                        end
                    end
                end
                CMD_SET_IPI: begin
                    ipi_prio_d = wr_prio;
                    if (ipi_fire) begin
                        if (slot_q == SLOT_SOURCE) begin
                            rej_v_d = 1'b1;
                            rej_s_d = xisr_q;
                        end
                        slot_d      = SLOT_IPI;
                        xisr_d      = IPI_SRC;
                        pend_prio_d = ipi_eff;
                    end
                end
                CMD_POLL: begin
                    rsp_v_d = 1'b1;
                    rsp_w_d = {cppr_q, xisr_q};
                    rsp_i_d = ipi_prio_q;
                end
                default: begin
                end
            endcase
        end else if (arr_valid && (arr_src != '0)) begin
            if (arr_take) begin
                if (slot_q == SLOT_SOURCE) begin
                    rej_v_d = 1'b1;
                    rej_s_d = xisr_q;
                end
                slot_d      = SLOT_SOURCE;
                xisr_d      = arr_src;
                pend_prio_d = arr_prio;
            end else begin
                rej_v_d = 1'b1;
                rej_s_d = arr_src;
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q      <= SLOT_EMPTY;
            xisr_q      <= '0;
            cppr_q      <= '0;
            pend_prio_q <= PRIO_NONE;
            ipi_prio_q  <= PRIO_NONE;
        end else begin
            slot_q      <= slot_d;
            xisr_q      <= xisr_d;
            cppr_q      <= cppr_d;
            pend_prio_q <= pend_prio_d;
            ipi_prio_q  <= ipi_prio_d;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_word   <= '0;
            rsp_ipi    <= '0;
            rej_valid  <= 1'b0;
            rej_src    <= '0;
            eoi_valid  <= 1'b0;
            eoi_src    <= '0;
            resend_req <= 1'b0;
            irq_out    <= 1'b0;
        end else begin
            rsp_valid  <= rsp_v_d;
            rsp_word   <= rsp_w_d;
            rsp_ipi    <= rsp_i_d;
            rej_valid  <= rej_v_d;
            rej_src    <= rej_s_d;
            eoi_valid  <= eoi_v_d;
            eoi_src    <= eoi_s_d;
            resend_req <= resend_d;
            irq_out    <= (slot_d != SLOT_EMPTY);
        end
    end

endmodule

// File: rtl/irqp_checker.sv
module irqp_checker #(
    parameter int SRC_W  = 24,
    parameter int PRIO_W = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    arr_valid,
    input logic [SRC_W-1:0]        arr_src,
    input logic [PRIO_W-1:0]       arr_prio,
    input logic                    cmd_valid,
    input logic [2:0]              cmd_op,
    input logic [PRIO_W+SRC_W-1:0] cmd_data,
    input logic                    rsp_valid,
    input logic [PRIO_W+SRC_W-1:0] rsp_word,
    input logic                    rej_valid,
    input logic [SRC_W-1:0]        rej_src,
    input logic                    eoi_valid,
    input logic [SRC_W-1:0]        eoi_src,
    input logic                    resend_req,
    input logic                    irq_out,
    input logic [PRIO_W-1:0]       cppr_q,
    input logic [SRC_W-1:0]        xisr_q
);
    // R3: an arrival that is not better than the processor is handed straight back
    assert_low_arrival_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_valid && !cmd_valid && arr_src != '0 && arr_prio >= cppr_q)
        |=> (rej_valid && rej_src == $past(arr_src) && irq_out == $past(irq_out)));

    // R2: poll answers and disturbs nothing
    assert_poll_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd4)
        |=> (rsp_valid && !rej_valid && !resend_req && irq_out == $past(irq_out)));

    // R6: accept returns the word and drops the line
    assert_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd0)
        |=> (rsp_valid && !irq_out && rsp_word == $past({cppr_q, xisr_q})));

    // R11: end-of-interrupt forwards the low field
    assert_eoi_forward_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd1)
        |=> (eoi_valid && eoi_src == $past(cmd_data[SRC_W-1:0])));

    // R10: a resend only follows a priority write or an end-of-interrupt
    assert_resend_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        resend_req |-> $past(cmd_valid && (cmd_op == 3'd1 || cmd_op == 3'd2)));

    // R12: source number zero never travels back
    assert_no_zero_reject_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rej_valid |-> (rej_src != '0));

endmodule

bind irq_presenter irqp_checker #(.SRC_W(SRC_W), .PRIO_W(PRIO_W)) u_irqp_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .arr_valid (arr_valid),
    .arr_src   (arr_src),
    .arr_prio  (arr_prio),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_data  (cmd_data),
    .rsp_valid (rsp_valid),
    .rsp_word  (rsp_word),
    .rej_valid (rej_valid),
    .rej_src   (rej_src),
    .eoi_valid (eoi_valid),
    .eoi_src   (eoi_src),
    .resend_req(resend_req),
    .irq_out   (irq_out),
    .cppr_q    (cppr_q),
    .xisr_q    (xisr_q)
);

// File: tb/test_irq_presenter.sv
module test_irq_presenter;

    localparam logic [2:0] OP_ACC = 3'd0, OP_EOI = 3'd1, OP_PRIO = 3'd2,
                           OP_IPI = 3'd3, OP_POLL = 3'd4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arr_valid = 1'b0;
    logic [23:0] arr_src = '0;
    logic [7:0]  arr_prio = '0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [31:0] cmd_data = '0;
    logic        rsp_valid, rej_valid, eoi_valid, resend_req, irq_out;
    logic [31:0] rsp_word;
    logic [7:0]  rsp_ipi;
    logic [23:0] rej_src, eoi_src;

    always #5 clk = ~clk;

    irq_presenter i_irq_presenter (
        .clk(clk), .rst_n(rst_n),
        .arr_valid(arr_valid), .arr_src(arr_src), .arr_prio(arr_prio),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
        .rsp_valid(rsp_valid), .rsp_word(rsp_word), .rsp_ipi(rsp_ipi),
        .rej_valid(rej_valid), .rej_src(rej_src),
        .eoi_valid(eoi_valid), .eoi_src(eoi_src),
        .resend_req(resend_req), .irq_out(irq_out)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state
    logic [7:0]  m_cppr = 8'h00;
    logic [23:0] m_xisr = '0;
    logic [7:0]  m_pp = 8'hFF;
    logic [7:0]  m_mfrr = 8'hFF;
    bit          m_ipi_owned = 1'b0;

    // Expected outputs
    bit          e_rej, e_eoi, e_res, e_rsp;
    logic [23:0] e_rsrc, e_esrc;
    logic [31:0] e_rw;
    logic [7:0]  e_ri;

    function automatic bit ipi_go(input logic [7:0] mf, input logic [7:0] cp);
        return (mf < cp) && !((m_xisr != 0) && (m_pp <= mf));
    endfunction

    task automatic give_back_held();
        if (m_xisr != 0 && !m_ipi_owned) begin
            e_rej = 1'b1;
            e_rsrc = m_xisr;
        end
    endtask

    task automatic load_ipi(input logic [7:0] mf);
        m_xisr = 24'd2;
        m_pp = mf;
        m_ipi_owned = 1'b1;
    endtask

    task automatic step(input bit av, input logic [23:0] asrc, input logic [7:0] apr,
                        input bit cv, input logic [2:0] op, input logic [31:0] d,
                        input string tag);
        logic [7:0] oldc;
        arr_valid = av; arr_src = asrc; arr_prio = apr;
        cmd_valid = cv; cmd_op = op; cmd_data = d;
        e_rej = 0; e_rsrc = 0; e_eoi = 0; e_esrc = 0; e_res = 0; e_rsp = 0; e_rw = 0; e_ri = 0;
        if (cv) begin
            case (op)
                OP_ACC: begin
                    e_rsp = 1; e_rw = {m_cppr, m_xisr}; e_ri = m_mfrr;
                    m_cppr = m_pp; m_xisr = 0; m_pp = 8'hFF; m_ipi_owned = 0;
                end
                OP_EOI: begin
                    m_cppr = d[31:24]; e_eoi = 1; e_esrc = d[23:0];
                    if (m_xisr == 0) begin
                        e_res = 1;
                        if (ipi_go(m_mfrr, m_cppr)) load_ipi(m_mfrr);
                    end
                end
                OP_PRIO: begin
                    oldc = m_cppr;
                    m_cppr = d[7:0];
                    if (d[7:0] < oldc) begin
                        if (m_xisr != 0 && d[7:0] <= m_pp) begin
                            give_back_held();
                            m_xisr = 0; m_pp = 8'hFF; m_ipi_owned = 0;
                        end
                    end else if (m_xisr == 0) begin
                        e_res = 1;
                        if (ipi_go(m_mfrr, m_cppr)) load_ipi(m_mfrr);
                    end
                end
                OP_IPI: begin
                    m_mfrr = d[7:0];
                    if (ipi_go(m_mfrr, m_cppr)) begin
                        give_back_held();
                        load_ipi(m_mfrr);
                    end
                end
                OP_POLL: begin
                    e_rsp = 1; e_rw = {m_cppr, m_xisr}; e_ri = m_mfrr;
                end
                default: ;
            endcase
        end else if (av && asrc != 0) begin
            if (apr < m_cppr && !(m_xisr != 0 && m_pp <= apr)) begin
                give_back_held();
                m_xisr = asrc; m_pp = apr; m_ipi_owned = 0;
            end else begin
                e_rej = 1; e_rsrc = asrc;
            end
        end
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (irq_out !== (m_xisr != 0) || rej_valid !== e_rej || (e_rej && rej_src !== e_rsrc)
            || eoi_valid !== e_eoi || (e_eoi && eoi_src !== e_esrc) || resend_req !== e_res
            || rsp_valid !== e_rsp || (e_rsp && (rsp_word !== e_rw || rsp_ipi !== e_ri))) begin
            errors++;
            $display("FAIL %s: got irq=%0b rej=%0b/%h eoi=%0b/%h res=%0b rsp=%0b/%h/%h exp irq=%0b rej=%0b/%h eoi=%0b/%h res=%0b rsp=%0b/%h/%h",
                     tag, irq_out, rej_valid, rej_src, eoi_valid, eoi_src, resend_req,
                     rsp_valid, rsp_word, rsp_ipi, (m_xisr != 0), e_rej, e_rsrc, e_eoi,
                     e_esrc, e_res, e_rsp, e_rw, e_ri);
        end
        arr_valid = 0; cmd_valid = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state seen at the ports and through poll
        step(0, 0, 0, 0, 0, 0, "R1");
        step(0, 0, 0, 1, OP_POLL, 0, "R1");
        step(0, 0, 0, 1, 3'd6, 32'hFFFF_FFFF, "R2");     // unused code
        step(0, 0, 0, 1, OP_POLL, 0, "R2");
        step(1, 24'd5, 8'd3, 0, 0, 0, "R3");               // prio 3 vs current 0
        step(0, 0, 0, 1, OP_PRIO, 32'hFF, "R10");          // raise, nothing held
        step(1, 24'd5, 8'd8, 0, 0, 0, "R5");
        step(1, 24'd7, 8'd8, 0, 0, 0, "R4");               // equal to held
        step(1, 24'd9, 8'd4, 0, 0, 0, "R5");               // displaces 5
        step(0, 0, 0, 1, OP_POLL, 0, "R2");
        step(0, 0, 0, 1, OP_ACC, 0, "R6");
        step(1, 24'd0, 8'd1, 0, 0, 0, "R12");
        step(0, 0, 0, 1, OP_POLL, 0, "R12");
        step(0, 0, 0, 1, OP_EOI, 32'hFF00_0009, "R11");
        step(0, 0, 0, 1, OP_IPI, 32'h06, "R7");
        step(1, 24'd11, 8'd2, 0, 0, 0, "R8");              // displaces IPI silently
        step(0, 0, 0, 1, OP_IPI, 32'h01, "R7");            // displaces 11
        step(0, 0, 0, 1, OP_PRIO, 32'h01, "R8");           // clears IPI silently
        step(0, 0, 0, 1, OP_PRIO, 32'h10, "R10");          // resend plus IPI load
        step(0, 0, 0, 1, OP_ACC, 0, "R6");
        step(0, 0, 0, 1, OP_IPI, 32'hFF, "R7");
        step(0, 0, 0, 1, OP_EOI, 32'h3000_0002, "R11");
        step(1, 24'd20, 8'h20, 0, 0, 0, "R5");
        step(0, 0, 0, 1, OP_PRIO, 32'h28, "R9");           // lower, held stays
        step(0, 0, 0, 1, OP_PRIO, 32'h28, "R10");          // equal, held: no resend
        step(0, 0, 0, 1, OP_PRIO, 32'h20, "R9");           // clears 20
        step(1, 24'd21, 8'h05, 0, 0, 0, "R5");
        step(0, 0, 0, 1, OP_EOI, 32'h3000_0003, "R11");    // held: no resend
        step(0, 0, 0, 1, OP_POLL, 0, "R2");
        step(0, 0, 0, 0, 0, 0, "R1");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule